// File: doc/BRIEF.md
# ADC Scan Transfer Engine

This block moves conversion results from a multichannel ADC into register-file RAM without CPU help, and it sets the order in which the inputs are scanned. After it is enabled, it starts a conversion on input 0. When the ADC reports that a 16-bit result is ready, the engine asks the CPU for the system bus. Once the CPU grants the bus, it stores the result as two bytes and then gives the bus back.

Each result lands at an address built from three parts: a 7-bit base taken from configuration, the 4-bit channel number, and a byte-select bit. The high byte goes to the even address and the low byte to the odd one. After each transfer the engine starts the next higher input. After the highest configured input it returns to input 0 and, if enabled, raises a one-cycle interrupt. Clearing the enable bit stops the scan once any bus transfer already under way has finished.

Top module: `adc_scan_dma`

## Requirements
- R1: While reset is held, and until the engine is enabled, bus_req, ram_we, adc_start and irq are all 0.
- R2: When cfg_en is sampled high in the idle state, adc_start is high for exactly one cycle in the next cycle, with adc_chan = 0.
- R3: When adc_done is sampled high while a conversion is awaited, bus_req is 1 from the next cycle. No RAM write happens until bus_ack has been sampled high.
- R4: In the cycle after bus_ack is sampled high, ram_we is 1 with ram_addr = {base, channel, 1'b0} and the result's upper 8 bits. In the following cycle, ram_we is 1 with ram_addr = {base, channel, 1'b1} and the lower 8 bits.
- R5: bus_req stays 1 through both writes and is 0 in the cycle after the odd-address write.
- R6: When the channel just written is below cfg_last_ch, adc_start pulses in the cycle after the odd-address write, with adc_chan one higher.
- R7: When the channel just written is at or above cfg_last_ch, the next adc_start uses adc_chan = 0. This includes the case cfg_last_ch = 0.
- R8: irq is a one-cycle pulse in the cycle after the odd-address write of a wrapping channel, and only if cfg_irq_en is 1. Otherwise irq stays 0.
- R9: If cfg_en is cleared during a bus transfer, both bytes are still written and no further adc_start follows. If it is cleared while a conversion is awaited, the engine goes idle and adc_done then causes no bus_req. Re-enabling starts again at channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Scan enable |
| cfg_irq_en | input | 1 | Interrupt on scan wrap enable |
| cfg_last_ch | input | 4 | Highest input number to convert |
| cfg_base | input | 7 | Upper 7 bits of the destination address |
| adc_done | input | 1 | Conversion result ready |
| adc_data | input | 16 | Conversion result |
| adc_start | output | 1 | Start conversion pulse |
| adc_chan | output | 4 | Input to convert |
| bus_req | output | 1 | System bus request to the CPU |
| bus_ack | input | 1 | System bus grant from the CPU |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 12 | RAM byte address |
| ram_wdata | output | 8 | RAM write byte |
| irq | output | 1 | Scan-complete interrupt pulse |

## Verification
Every result appears a fixed number of register stages after the input that causes it:
- bus_req rises one cycle after adc_done.
- The even-address write comes one cycle after bus_ack is sampled, and the odd-address write one cycle after that.
- bus_req falls, adc_start pulses and irq appears together, one cycle after the odd-address write.

The bench drives every input on the falling edge and checks each output at the falling edge of exactly the cycle where it is due. While the grant is held back, it checks at each wait cycle that no write has begun.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;
    localparam int BASE_W = 7;
    localparam int CH_W   = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int ADDR_W = BASE_W + CH_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT,
        ST_REQ,
        ST_WR_HI,
        ST_WR_LO
    } dma_state_e;

    typedef struct packed {
        dma_state_e        st;
        logic [CH_W-1:0]   ch;
        logic [WORD_W-1:0] word;
        logic              irq;
    } dma_regs_t;
endpackage

// File: rtl/adc_dma_chan_seq.sv
module adc_dma_chan_seq #(
    parameter int CH_W = 4
) (
    input  logic [CH_W-1:0] cur_ch,
    input  logic [CH_W-1:0] last_ch,
    output logic [CH_W-1:0] next_ch,
    output logic            wrap
);
    always_comb begin
        wrap    = (cur_ch >= last_ch);
        next_ch = wrap ? '0 : cur_ch + 1'b1;
    end
endmodule

// File: rtl/adc_dma_wr_mux.sv
module adc_dma_wr_mux #(
    parameter int BASE_W = 7,
    parameter int CH_W   = 4,
    parameter int BYTE_W = 8,
    localparam int ADDR_W = BASE_W + CH_W + 1
) (
    input  logic [BASE_W-1:0]   base,
    input  logic [CH_W-1:0]     ch,
    input  logic [2*BYTE_W-1:0] word,
    input  logic                sel_lo,
    output logic [ADDR_W-1:0]   addr,
    output logic [BYTE_W-1:0]   wdata
);
    always_comb begin
        addr  = {base, ch, sel_lo};
        wdata = sel_lo ? word[BYTE_W-1:0] : word[2*BYTE_W-1:BYTE_W];
    end
endmodule

// File: rtl/adc_scan_dma.sv
module adc_scan_dma
    import adc_dma_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_en,
    input  logic                cfg_irq_en,
    input  logic [CH_W-1:0]     cfg_last_ch,
    input  logic [BASE_W-1:0]   cfg_base,
    input  logic                adc_done,
    input  logic [WORD_W-1:0]   adc_data,
    output logic                adc_start,
    output logic [CH_W-1:0]     adc_chan,
    output logic                bus_req,
    input  logic                bus_ack,
    output logic                ram_we,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic [BYTE_W-1:0]   ram_wdata,
    output logic                irq
);
    dma_regs_t       r_q, r_d;
    logic [CH_W-1:0] nxt_ch;
    logic            wrap;

    adc_dma_chan_seq #(.CH_W(CH_W)) i_seq (
        .cur_ch  (r_q.ch),
        .last_ch (cfg_last_ch),
        .next_ch (nxt_ch),
        .wrap    (wrap)
    );

    adc_dma_wr_mux #(.BASE_W(BASE_W), .CH_W(CH_W), .BYTE_W(BYTE_W)) i_mux (
        .base   (cfg_base),
        .ch     (r_q.ch),
        .word   (r_q.word),
        .sel_lo (r_q.st == ST_WR_LO),
        .addr   (ram_addr),
        .wdata  (ram_wdata)
    );

    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                r_d.ch = '0;
                if (cfg_en) r_d.st = ST_START;
            end
            ST_START: r_d.st = ST_WAIT;
            ST_WAIT: begin
                if (!cfg_en) begin
                    r_d.st = ST_IDLE;
                end else if (adc_done) begin
                    r_d.word = adc_data;
                    r_d.st   = ST_REQ;
                end
            end
            ST_REQ:   if (bus_ack) r_d.st = ST_WR_HI;
            ST_WR_HI: r_d.st = ST_WR_LO;
            ST_WR_LO: begin
                r_d.ch  = nxt_ch;
                r_d.irq = wrap & cfg_irq_en;
                r_d.st  = cfg_en ? ST_START : ST_IDLE;
            end
            default:  r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, ch: '0, word: '0, irq: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        adc_start = (r_q.st == ST_START);
        adc_chan  = r_q.ch;
        ram_we    = (r_q.st == ST_WR_HI) || (r_q.st == ST_WR_LO);
        bus_req   = ram_we || (r_q.st == ST_REQ);
        irq       = r_q.irq;
    end
endmodule

// File: rtl/adc_scan_dma_chk.sv
module adc_scan_dma_chk
    import adc_dma_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            bus_req,
    input logic            bus_ack,
    input logic            ram_we,
    input logic [CH_W:0]   ram_lsb,
    input logic            adc_start,
    input logic [CH_W-1:0] adc_chan,
    input logic            irq,
    input logic [CH_W-1:0] cfg_last_ch,
    input logic            cfg_irq_en
);
    assert_we_under_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> bus_req);

    assert_write_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we) |-> ($past(bus_ack) && $past(bus_req)));

    assert_lo_follows_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !ram_lsb[0]) |=> (ram_we && ram_lsb[0]));

    assert_req_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_lsb[0]) |=> !bus_req);

    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(ram_we) && $past(ram_lsb[0]) && $past(cfg_irq_en)));

    assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_next_chan_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_start && $past(ram_we) && ($past(ram_lsb[CH_W:1]) < $past(cfg_last_ch)))
        |-> (adc_chan == $past(ram_lsb[CH_W:1]) + 1'b1));

    assert_wrap_chan_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_start && $past(ram_we) && ($past(ram_lsb[CH_W:1]) >= $past(cfg_last_ch)))
        |-> (adc_chan == '0));
endmodule

bind adc_scan_dma adc_scan_dma_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_ack     (bus_ack),
    .ram_we      (ram_we),
    .ram_lsb     (ram_addr[adc_dma_pkg::CH_W:0]),
    .adc_start   (adc_start),
    .adc_chan    (adc_chan),
    .irq         (irq),
    .cfg_last_ch (cfg_last_ch),
    .cfg_irq_en  (cfg_irq_en)
);

// File: tb/test_adc_scan_dma.sv
module test_adc_scan_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_irq_en = 1'b0;
    logic [3:0]  cfg_last_ch = '0;
    logic [6:0]  cfg_base = '0;
    logic        adc_done = 1'b0;
    logic [15:0] adc_data = '0;
    logic        adc_start;
    logic [3:0]  adc_chan;
    logic        bus_req;
    logic        bus_ack = 1'b0;
    logic        ram_we;
    logic [11:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        irq;

    int nvec = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    adc_scan_dma i_adc_scan_dma (.*);

    // {result word, grant delay in cycles}
    localparam logic [19:0] VEC [6] = '{
        {16'hA5C3, 4'd0}, {16'h0001, 4'd2}, {16'hFF00, 4'd1},
        {16'h1234, 4'd5}, {16'h8000, 4'd0}, {16'h7FFE, 4'd3}
    };

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic xfer(input int ch, input logic [15:0] d, input int dly, input bit drop_en);
        int nxt;
        bit wr;
        wr  = (ch >= int'(cfg_last_ch));
        nxt = wr ? 0 : ch + 1;
        @(negedge clk);
        adc_done = 1'b1; adc_data = d;
        @(negedge clk);
        adc_done = 1'b0;
        if (drop_en) cfg_en = 1'b0;
        chk("R3 bus_req after done", int'(bus_req), 1);
        chk("R3 no write before grant", int'(ram_we), 0);
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            chk("R3 waiting for grant", int'(ram_we), 0);
        end
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        chk("R4 even write", int'(ram_we), 1);
        chk("R4 even addr", int'(ram_addr), int'({cfg_base, ch[3:0], 1'b0}));
        chk("R4 high byte", int'(ram_wdata), int'(d[15:8]));
        @(negedge clk);
        chk("R4 odd write", int'(ram_we), 1);
        chk("R4 odd addr", int'(ram_addr), int'({cfg_base, ch[3:0], 1'b1}));
        chk("R4 low byte", int'(ram_wdata), int'(d[7:0]));
        chk("R5 req held", int'(bus_req), 1);
        @(negedge clk);
        chk("R5 req released", int'(bus_req), 0);
        chk("R9/R6 next start", int'(adc_start), drop_en ? 0 : 1);
        if (!drop_en) chk(wr ? "R7 wrap chan" : "R6 next chan", int'(adc_chan), nxt);
        chk("R8 irq", int'(irq), int'(wr && cfg_irq_en));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset bus_req", int'(bus_req), 0);
        chk("R1 reset ram_we", int'(ram_we), 0);
        chk("R1 reset adc_start", int'(adc_start), 0);
        chk("R1 reset irq", int'(irq), 0);
        rst_n = 1'b1;
        cfg_base = 7'h35; cfg_last_ch = 4'd2; cfg_irq_en = 1'b1;
        @(negedge clk);
        chk("R1 idle", int'(adc_start), 0);
        cfg_en = 1'b1;
        @(negedge clk);
        chk("R2 start", int'(adc_start), 1);
        chk("R2 chan0", int'(adc_chan), 0);

        for (int i = 0; i < 6; i++)
            xfer(i % 3, VEC[i][19:4], int'(VEC[i][3:0]), 1'b0);

        // R8: interrupt disabled over a full scan
        cfg_irq_en = 1'b0;
        for (int i = 0; i < 3; i++) xfer(i, 16'h5A00 + 16'(i), 1, 1'b0);

        // R9: disable during a bus transfer
        cfg_irq_en = 1'b1;
        xfer(0, 16'hBEEF, 2, 1'b1);
        @(negedge clk);
        adc_done = 1'b1;
        @(negedge clk);
        adc_done = 1'b0;
        chk("R9 idle start", int'(adc_start), 0);
        @(negedge clk);
        chk("R9 done ignored", int'(bus_req), 0);

        // R9: re-enable restarts at channel 0
        cfg_en = 1'b1;
        @(negedge clk);
        chk("R9 restart", int'(adc_start), 1);
        chk("R9 restart chan", int'(adc_chan), 0);
        xfer(0, 16'h0F0F, 0, 1'b0);

        // R9: disable while waiting for a conversion
        @(negedge clk);
        cfg_en = 1'b0;
        @(negedge clk);
        adc_done = 1'b1;
        @(negedge clk);
        adc_done = 1'b0;
        chk("R9 wait abort", int'(bus_req), 0);
        @(negedge clk);
        chk("R9 wait abort later", int'(bus_req), 0);

        // R7: single-channel scan
        cfg_last_ch = 4'd0;
        cfg_en = 1'b1;
        @(negedge clk);
        chk("R7 start single", int'(adc_chan), 0);
        xfer(0, 16'hC001, 1, 1'b0);
        xfer(0, 16'h3CC3, 0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        #400000;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule